// File: doc/BRIEF.md
# Self-Synchronising Bit Scrambler / Descrambler

This block whitens a serial bit stream with a multiplicative (self-synchronising) scrambler, or undoes that whitening, one bit at a time. A single shift register of programmable length (1 to 32 bits) is used for both directions. A polynomial mask selects which register stages are folded into a parity term. A mode input picks the direction: scramble or descramble. Each accepted input bit advances the register by exactly one step. The result appears on the output one registered cycle later, with its own valid flag.

The two directions differ only in what is shifted into the register's top stage. The scrambler shifts in its own computed bit. The descrambler shifts in the received line bit, so it needs no shared seed. After `len` received bits it reproduces the original data, delayed by `len` bits. A seed value is loaded on reset or when the load strobe is high, which gives a known starting state for tests or for framed use.

Top module: `scr_mult_top`

## Requirements
- R1: Reset, and any cycle with `load` high, places `seed` masked to the effective length into the register. While reset is active, `dout` and `dout_valid` read 0.
- R2: `dout_valid` is `din_valid` delayed by one clock. It is 0 in the cycle after a load.
- R3: The feedback bit is the XOR of all register stages below the effective length whose mask bit is 1. Mask bits at or above the effective length have no effect.
- R4: With `mode`=0 (scramble), `dout` is the register's bit 0 and the bit shifted in is feedback XOR `din`.
- R5: With `mode`=1 (descramble), `dout` is feedback XOR `din` and the bit shifted in is `din`.
- R6: Each accepted bit shifts the register right by one stage and writes the new bit at stage `len`-1. Straight after a load, the first `len` scrambled outputs are therefore the seed bits, least significant first.
- R7: In a cycle with `din_valid` low and no load, neither the register nor `dout` changes.
- R8: A `len` of 0 acts as length 1. A `len` above 32 acts as length 32.
- R9: A descrambler fed with a scrambler's output, under the same mask and length but any seed, outputs the scrambler's input delayed by `len` bits once `len` bits have been received.
- R10: When `load` and `din_valid` are both high in the same cycle, the load wins and the input bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the seed |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| load | input | 1 | Reload the register from `seed` this cycle |
| mask | input | 32 | Feedback polynomial tap mask, bit k taps stage k |
| seed | input | 32 | Initial register contents |
| len | input | 6 | Register length in stages (1..32) |
| din | input | 1 | Input bit |
| din_valid | input | 1 | `din` is valid and is consumed this cycle |
| dout | output | 1 | Output bit |
| dout_valid | output | 1 | `dout` is valid (one cycle after `din_valid`) |

## Verification
The assertions assume that `len`, `mask` and `mode` stay constant between loads. They also assume that `seed` and `len` are stable in a load cycle, so that the register's contents can be compared with the masked seed. The bench changes configuration only in a load cycle, followed by a run of bits, and varies only `din` and `din_valid` inside a run. Each run checks every output bit against an arithmetic model. Each run inserts idle cycles at a fixed stride, and reuses the scrambled stream as input to a descrambler seeded differently.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Direction selected by the mode input.
    typedef enum logic {
        MODE_SCRAMBLE   = 1'b0,
        MODE_DESCRAMBLE = 1'b1
    } scr_mode_e;

endpackage

// File: rtl/scr_len_decode.sv
// Clamps the requested length to 1..W and expands it into a stage-keep mask
// and the index of the top (newest) stage.
module scr_len_decode #(
    parameter int W  = 32,
    parameter int LW = $clog2(W + 1),
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [LW-1:0] len,
    output logic [W-1:0]  keep,
    output logic [IW-1:0] top_idx
);
    logic [LW-1:0] len_eff;

    always_comb begin
        if (len == '0) begin
            len_eff = LW'(1);
        end else if (len > LW'(W)) begin
            len_eff = LW'(W);
        end else begin
            len_eff = len;
        end
        top_idx = IW'(len_eff - LW'(1));
    end

    for (genvar i = 0; i < W; i++) begin : g_keep
        assign keep[i] = (LW'(i) < len_eff);
    end
endmodule

// File: rtl/scr_feedback.sv
// Parity of the register stages that are both tapped and inside the length.
module scr_feedback #(
    parameter int W = 32
) (
    input  logic [W-1:0] sr,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] keep,
    output logic         fb
);
    logic [W-1:0] tapped;
    logic [W:0]   chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_tap
        assign tapped[i]  = sr[i] & mask[i] & keep[i];
        assign chain[i+1] = chain[i] ^ tapped[i];
    end
    assign fb = chain[W];
endmodule

// File: rtl/scr_bit_path.sv
// Direction-dependent choice of the output bit and the bit shifted in.
module scr_bit_path
    import scr_pkg::*;
(
    input  scr_mode_e mode,
    input  logic      din,
    input  logic      fb,
    input  logic      lsb,
    output logic      out_bit,
    output logic      new_bit
);
    always_comb begin
        unique case (mode)
            MODE_SCRAMBLE: begin
                out_bit = lsb;
                new_bit = fb ^ din;
            end
            MODE_DESCRAMBLE: begin
                out_bit = fb ^ din;
                new_bit = din;
            end
            default: begin
                out_bit = lsb;
                new_bit = fb ^ din;
            end
        endcase
    end
endmodule

// File: rtl/scr_mult_top.sv
module scr_mult_top
    import scr_pkg::*;
#(
    parameter int W  = 32,
    localparam int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          load,
    input  logic [W-1:0]  mask,
    input  logic [W-1:0]  seed,
    input  logic [LW-1:0] len,
    input  logic          din,
    input  logic          din_valid,
    output logic          dout,
    output logic          dout_valid
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0] sr;
        logic         dout;
        logic         vld;
    } scr_state_t;

    scr_state_t st_d, st_q;

    logic [W-1:0]  keep;
    logic [IW-1:0] top_idx;
    logic          fb;
    logic          out_bit;
    logic          new_bit;
    scr_mode_e     mode_e;

    assign mode_e = scr_mode_e'(mode);

    scr_len_decode #(.W(W), .LW(LW), .IW(IW)) u_len (
        .len     (len),
        .keep    (keep),
        .top_idx (top_idx)
    );

    scr_feedback #(.W(W)) u_fb (
        .sr   (st_q.sr),
        .mask (mask),
        .keep (keep),
        .fb   (fb)
    );

    scr_bit_path u_path (
        .mode    (mode_e),
        .din     (din),
        .fb      (fb),
        .lsb     (st_q.sr[0]),
        .out_bit (out_bit),
        .new_bit (new_bit)
    );

    // Next-state logic: load beats a valid bit; idle holds everything.
    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (load) begin
            st_d.sr = seed & keep;
        end else if (din_valid) begin
            st_d.sr          = (st_q.sr >> 1) & (keep >> 1);
            st_d.sr[top_idx] = new_bit;
            st_d.dout        = out_bit;
            st_d.vld         = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr   <= seed & keep;
            st_q.dout <= 1'b0;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.dout;
    assign dout_valid = st_q.vld;
endmodule

// File: rtl/scr_mult_chk.sv
module scr_mult_chk #(
    parameter int W  = 32,
    parameter int LW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode,
    input logic          load,
    input logic [W-1:0]  seed,
    input logic [LW-1:0] len,
    input logic          din,
    input logic          din_valid,
    input logic          dout,
    input logic          dout_valid,
    input logic [W-1:0]  sr_q
);
    function automatic int eff_len(logic [LW-1:0] l);
        if (l == '0) return 1;
        if (int'(l) > W) return W;
        return int'(l);
    endfunction

    function automatic logic [W-1:0] keep_of(logic [LW-1:0] l);
        logic [W-1:0] k;
        k = '0;
        for (int i = 0; i < W; i++) begin
            if (i < eff_len(l)) k[i] = 1'b1;
        end
        return k;
    endfunction

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !load) |=> dout_valid);

    p_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_valid || load) |=> !dout_valid);

    p_load_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sr_q == ($past(seed) & keep_of($past(len)))));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && din_valid) |=> !dout_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_valid && !load) |=> ($stable(sr_q) && $stable(dout)));

    p_scr_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !load && !mode) |=> (dout == $past(sr_q[0])));

    p_desc_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !load && mode) |=> (sr_q[eff_len($past(len)) - 1] == $past(din)));

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !load) |=>
        (((($past(sr_q) >> 1) ^ sr_q) & (keep_of($past(len)) >> 1)) == '0));
endmodule

bind scr_mult_top scr_mult_chk #(.W(W), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .load       (load),
    .seed       (seed),
    .len        (len),
    .din        (din),
    .din_valid  (din_valid),
    .dout       (dout),
    .dout_valid (dout_valid),
    .sr_q       (st_q.sr)
);

// File: tb/tb_scr_mult_top.sv
module tb_scr_mult_top;
    localparam int  W = 32;
    localparam int  LW = 6;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NMAX = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          load = 1'b0;
    logic [W-1:0]  mask = '0;
    logic [W-1:0]  seed = '0;
    logic [LW-1:0] len = '0;
    logic          din = 1'b0;
    logic          din_valid = 1'b0;
    logic          dout;
    logic          dout_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_st;
    int           m_len;

    logic xs [NMAX];
    logic ys [NMAX];

    always #(CLK_PERIOD / 2) clk = ~clk;

    scr_mult_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .load(load), .mask(mask),
        .seed(seed), .len(len), .din(din), .din_valid(din_valid),
        .dout(dout), .dout_valid(dout_valid)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(int l);
        if (l == 0) return 1;
        if (l > W) return W;
        return l;
    endfunction

    function automatic logic [W-1:0] keep(int l);
        if (l >= W) return '1;
        return (32'd1 << l) - 32'd1;
    endfunction

    // Arithmetic model of one step, per R3..R6.
    task automatic model_step(input bit md, input bit x, output bit y);
        bit fb, nb;
        fb = ^(m_st & mask & keep(m_len));
        if (!md) begin
            y  = m_st[0];
            nb = fb ^ x;
        end else begin
            y  = fb ^ x;
            nb = x;
        end
        m_st = (m_st >> 1) & (keep(m_len) >> 1);
        m_st[m_len-1] = nb;
    endtask

    task automatic do_load(logic [W-1:0] s, int l, logic [W-1:0] mk);
        @(negedge clk);
        load = 1'b1; seed = s; len = LW'(l); mask = mk; din_valid = 1'b0;
        @(posedge clk); #1;
        check("R2", 32'(dout_valid), 32'd0);
        m_len = eff(l);
        m_st  = s & keep(m_len);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic send(bit md, bit x, string tag, output bit y);
        bit e;
        @(negedge clk);
        mode = md; din = x; din_valid = 1'b1;
        model_step(md, x, e);
        @(posedge clk); #1;
        check(tag, 32'(dout), 32'(e));
        check("R2", 32'(dout_valid), 32'd1);
        y = dout;
    endtask

    task automatic idle();
        logic prev;
        @(negedge clk);
        din_valid = 1'b0;
        prev = dout;
        @(posedge clk); #1;
        check("R7", 32'(dout), 32'(prev));
        check("R2", 32'(dout_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lens [12] = '{1, 2, 3, 5, 7, 8, 13, 16, 31, 32, 0, 40};
        bit y;
        // R1: reset state and seed load.
        seed = 32'hA5C3_1E69; len = LW'(32); mask = 32'h8000_0057;
        #(CLK_PERIOD * 3);
        check("R1", 32'(dout_valid), 32'd0);
        check("R1", 32'(dout), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        m_len = 32; m_st = seed;
        for (int n = 0; n < 40; n++) begin
            send(1'b0, 1'(n % 3 == 0), (n < 32) ? "R1" : "R4", y);
        end

        // Sweep of lengths, masks and seeds; scramble then descramble.
        for (int c = 0; c < 12; c++) begin
            int l, le, nb;
            logic [W-1:0] mk;
            string tag;
            l  = lens[c];
            le = eff(l);
            nb = 3 * le + 8;
            mk = (c % 4 == 3) ? 32'hFFFF_FFFF : (32'(c) * 32'h9E37_79B9) ^ 32'h0000_0105;
            for (int n = 0; n < nb; n++) xs[n] = 1'(((n * 7 + c) % 11) > 4);
            do_load(32'h1234_5678 ^ (32'(c) << 9), l, mk);
            for (int n = 0; n < nb; n++) begin
                if (n % 5 == 4) idle();
                if (n < le) tag = "R6";
                else if (l == 0 || l > W) tag = "R8";
                else if ((mk & ~keep(le)) != '0) tag = "R3";
                else tag = "R4";
                send(1'b0, xs[n], tag, y);
                ys[n] = y;
            end
            do_load(32'hDEAD_BEEF ^ 32'(c * 77), l, mk);
            for (int n = 0; n < nb; n++) begin
                if (n % 7 == 6) idle();
                send(1'b1, ys[n], "R5", y);
                if (n >= le) check("R9", 32'(y), 32'(xs[n - le]));
            end
        end

        // R10: load and valid in the same cycle.
        do_load(32'h0000_00FF, 8, 32'h0000_008E);
        @(negedge clk);
        load = 1'b1; din_valid = 1'b1; din = 1'b1; seed = 32'h0000_005A;
        @(posedge clk); #1;
        check("R10", 32'(dout_valid), 32'd0);
        m_st = 32'h0000_005A;
        @(negedge clk);
        load = 1'b0; din_valid = 1'b0;
        for (int n = 0; n < 8; n++) send(1'b0, 1'b0, "R10", y);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule